// File: doc/BRIEF.md
# Exception State Register Unit

This unit keeps the exception state of a 32-bit RISC core: the saved return address, the recorded reason for the last trap, and a status word holding the interrupt enable, the mask and the exception-level flag. Each cycle it looks at the synchronous fault inputs from the pipeline and at the external interrupt lines. If one of them must be taken, it redirects fetch to a single fixed handler address in that same cycle. At the next clock edge it stores the faulting instruction's address, the encoded reason and the switch to kernel mode.

The pipeline presents the program counter after the increment, so the unit subtracts one instruction step before it stores the value. A return strobe clears the exception level, drops back to user mode and offers the saved address as the next fetch address. A read port returns the status, cause and return-address registers by register number, but only while the core runs in kernel mode. A write port loads the status word, and it is honoured only in kernel mode.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset, status, cause and saved address all read as zero, the core is in kernel mode, and no redirect is requested.
- R2: A taken trap raises `redirect_o` in the same cycle with `next_pc_o` = 0x8000_0180. From the next clock edge the saved address (register 14) reads as the sampled `pc_i` minus 4.
- R3: An undefined-instruction trap stores code 10 in cause bits 5:2. An overflow trap stores code 12. An interrupt stores code 0. All cause bits outside 5:2 and 15:8 read as zero.
- R4: If several sources are active in one cycle, undefined instruction wins over overflow, and both win over an interrupt.
- R5: An interrupt line i is taken only when status bit 0 (global enable) is 1, status bit 8+i (mask) is 1 and status bit 1 (exception level) is 0.
- R6: Cause bits 15:8 show the interrupt lines sampled at the previous clock edge, whether or not they were taken.
- R7: A taken trap sets status bit 1 and kernel mode at the next clock edge.
- R8: A return strobe with no trap raises `redirect_o` with `next_pc_o` equal to the saved address. At the next clock edge it clears status bit 1 and leaves kernel mode.
- R9: Register 12 reads as status, 13 as cause and 14 as the saved address. Any other number reads as zero. In user mode every read returns zero and `rd_denied_o` is 1.
- R10: A status write loads bits 0, 1 and 15:8 from `wr_data_i`, and the other bits read as zero. A write made in user mode has no effect.
- R11: A trap in the same cycle as a return strobe wins: the target is the handler address and kernel mode remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | 32 | Incremented PC of the instruction in the trap stage |
| ovf_i | input | 1 | Integer overflow fault |
| undef_i | input | 1 | Undefined-instruction fault |
| irq_i | input | 8 | External interrupt request lines |
| eret_i | input | 1 | Return-from-exception strobe |
| wr_en_i | input | 1 | Status write enable |
| wr_data_i | input | 32 | Status write data |
| rd_sel_i | input | 5 | Register number to read |
| rd_data_o | output | 32 | Read data |
| rd_denied_o | output | 1 | Read refused because the core is in user mode |
| redirect_o | output | 1 | Fetch must use `next_pc_o` |
| next_pc_o | output | 32 | Handler or return address |
| kernel_o | output | 1 | Core is in kernel mode |

## Verification
The bench builds the unit with its default parameters: eight interrupt lines, a four-byte step, the fixed handler address and the user-mode read guard enabled. With eight lines, every mask bit from 8 to 15 can be driven. The single-bit interrupt cases therefore check both ends of the mask field and its mirror. Because the read guard is enabled, the refused-read path and the user-mode write lockout can both be checked at the ports.

// File: rtl/exc_pkg.sv
package exc_pkg;
   localparam logic [3:0] CODE_IRQ   = 4'd0;
   localparam logic [3:0] CODE_UNDEF = 4'd10;
   localparam logic [3:0] CODE_OVF   = 4'd12;

   localparam logic [4:0] SEL_STATUS = 5'd12;
   localparam logic [4:0] SEL_CAUSE  = 5'd13;
   localparam logic [4:0] SEL_EPC    = 5'd14;

   localparam int CODE_LSB = 2;
   localparam int MASK_LSB = 8;
   localparam int BIT_IE   = 0;
   localparam int BIT_EXL  = 1;

   typedef struct packed {
      logic       take;
      logic       is_irq;
      logic [3:0] code;
   } trap_t;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_pkg::*;
#(
   parameter int IRQ_N = 8
) (
   input  logic             undef_i,
   input  logic             ovf_i,
   input  logic [IRQ_N-1:0] irq_i,
   input  logic             ie_i,
   input  logic             exl_i,
   input  logic [IRQ_N-1:0] mask_i,
   output trap_t            trap_o
);
   logic [IRQ_N-1:0] live;
   logic             irq_ok;

   assign live   = irq_i & mask_i;
   assign irq_ok = ie_i & ~exl_i & (|live);

   always_comb begin
      trap_o = '0;
      if (undef_i) begin
         trap_o.take = 1'b1;
         trap_o.code = CODE_UNDEF;
      end else if (ovf_i) begin
         trap_o.take = 1'b1;
         trap_o.code = CODE_OVF;
      end else if (irq_ok) begin
         trap_o.take   = 1'b1;
         trap_o.is_irq = 1'b1;
         trap_o.code   = CODE_IRQ;
      end
   end
endmodule

// File: rtl/exc_status_reg.sv
module exc_status_reg
   import exc_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int IRQ_N = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_i,
   input  logic             eret_i,
   input  logic             wr_en_i,
   input  logic [XLEN-1:0]  wr_data_i,
   output logic             ie_o,
   output logic             exl_o,
   output logic [IRQ_N-1:0] mask_o,
   output logic             kernel_o,
   output logic [XLEN-1:0]  word_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ie_o     <= 1'b0;
         exl_o    <= 1'b0;
         mask_o   <= '0;
         kernel_o <= 1'b1;
      end else if (take_i) begin
         exl_o    <= 1'b1;
         kernel_o <= 1'b1;
      end else if (eret_i) begin
         exl_o    <= 1'b0;
         kernel_o <= 1'b0;
      end else if (wr_en_i && kernel_o) begin
         ie_o   <= wr_data_i[BIT_IE];
         exl_o  <= wr_data_i[BIT_EXL];
         mask_o <= wr_data_i[MASK_LSB +: IRQ_N];
      end
   end

   always_comb begin
      word_o                     = '0;
      word_o[BIT_IE]             = ie_o;
      word_o[BIT_EXL]            = exl_o;
      word_o[MASK_LSB +: IRQ_N]  = mask_o;
   end

   p_trap_enters_kernel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> (exl_o && kernel_o));

   p_eret_to_user_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (eret_i && !take_i) |=> (!exl_o && !kernel_o));

   p_user_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !kernel_o && !take_i && !eret_i) |=> $stable(word_o));
endmodule

// File: rtl/exc_capture.sv
module exc_capture
   import exc_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int IRQ_N   = 8,
   parameter int PC_STEP = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  trap_t            trap_i,
   input  logic [XLEN-1:0]  pc_i,
   input  logic [IRQ_N-1:0] irq_i,
   output logic [XLEN-1:0]  epc_o,
   output logic [XLEN-1:0]  cause_o
);
   localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

   logic [3:0]       code_q;
   logic [IRQ_N-1:0] pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         epc_o  <= '0;
         code_q <= '0;
         pend_q <= '0;
      end else begin
         pend_q <= irq_i;
         if (trap_i.take) begin
            epc_o  <= pc_i - STEP;
            code_q <= trap_i.code;
         end
      end
   end

   always_comb begin
      cause_o                     = '0;
      cause_o[CODE_LSB +: 4]      = code_q;
      cause_o[MASK_LSB +: IRQ_N]  = pend_q;
   end

   p_epc_back_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
      trap_i.take |=> (epc_o == $past(pc_i) - STEP));

   p_mirror_lines_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cause_o[MASK_LSB +: IRQ_N] == $past(irq_i)));
endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
   import exc_pkg::*;
#(
   parameter int          XLEN         = 32,
   parameter int          IRQ_N        = 8,
   parameter int          PC_STEP      = 4,
   parameter logic [31:0] HANDLER_ADDR = 32'h8000_0180,
   parameter bit          USER_GUARD   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [XLEN-1:0]  pc_i,
   input  logic             ovf_i,
   input  logic             undef_i,
   input  logic [IRQ_N-1:0] irq_i,
   input  logic             eret_i,
   input  logic             wr_en_i,
   input  logic [XLEN-1:0]  wr_data_i,
   input  logic [4:0]       rd_sel_i,
   output logic [XLEN-1:0]  rd_data_o,
   output logic             rd_denied_o,
   output logic             redirect_o,
   output logic [XLEN-1:0]  next_pc_o,
   output logic             kernel_o
);
   localparam logic [XLEN-1:0] HANDLER = XLEN'(HANDLER_ADDR);

   if (IRQ_N < 1 || IRQ_N > 8) begin : g_bad_irq_n
      $error("IRQ_N must lie in 1..8 to fit the mask field");
   end
   if (XLEN < 16) begin : g_bad_xlen
      $error("XLEN must be at least 16");
   end
   if (HANDLER_ADDR[1:0] != 2'b00) begin : g_bad_handler
      $error("HANDLER_ADDR must be word aligned");
   end

   trap_t            trap;
   logic             ie, exl;
   logic [IRQ_N-1:0] mask;
   logic [XLEN-1:0]  status_w, cause_w, epc_w;
   logic [XLEN-1:0]  sel_data;

   exc_arbiter #(.IRQ_N(IRQ_N)) u_arb (
      .undef_i (undef_i),
      .ovf_i   (ovf_i),
      .irq_i   (irq_i),
      .ie_i    (ie),
      .exl_i   (exl),
      .mask_i  (mask),
      .trap_o  (trap)
   );

   exc_status_reg #(.XLEN(XLEN), .IRQ_N(IRQ_N)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .take_i    (trap.take),
      .eret_i    (eret_i),
      .wr_en_i   (wr_en_i),
      .wr_data_i (wr_data_i),
      .ie_o      (ie),
      .exl_o     (exl),
      .mask_o    (mask),
      .kernel_o  (kernel_o),
      .word_o    (status_w)
   );

   exc_capture #(.XLEN(XLEN), .IRQ_N(IRQ_N), .PC_STEP(PC_STEP)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .trap_i  (trap),
      .pc_i    (pc_i),
      .irq_i   (irq_i),
      .epc_o   (epc_w),
      .cause_o (cause_w)
   );

   assign redirect_o = trap.take | eret_i;
   assign next_pc_o  = trap.take ? HANDLER : (eret_i ? epc_w : '0);

   always_comb begin
      case (rd_sel_i)
         SEL_STATUS: sel_data = status_w;
         SEL_CAUSE:  sel_data = cause_w;
         SEL_EPC:    sel_data = epc_w;
         default:    sel_data = '0;
      endcase
   end

   if (USER_GUARD) begin : g_guarded_read
      assign rd_denied_o = ~kernel_o;
      assign rd_data_o   = kernel_o ? sel_data : '0;
   end else begin : g_open_read
      assign rd_denied_o = 1'b0;
      assign rd_data_o   = sel_data;
   end

   p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (trap.is_irq) |-> (ie && !exl));

   p_undef_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
      undef_i |=> (cause_w[CODE_LSB +: 4] == CODE_UNDEF));

   p_handler_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (undef_i || ovf_i) |-> (redirect_o && next_pc_o == HANDLER));

   p_user_read_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (USER_GUARD && !kernel_o) |-> (rd_data_o == '0 && rd_denied_o));
endmodule

// File: tb/exc_ctrl_unit_bench.sv
module exc_ctrl_unit_bench;
   localparam logic [31:0] HANDLER = 32'h8000_0180;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pc_i = '0;
   logic        ovf_i = 1'b0, undef_i = 1'b0, eret_i = 1'b0, wr_en_i = 1'b0;
   logic [7:0]  irq_i = '0;
   logic [31:0] wr_data_i = '0;
   logic [4:0]  rd_sel_i = '0;
   logic [31:0] rd_data_o, next_pc_o;
   logic        rd_denied_o, redirect_o, kernel_o;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   exc_ctrl_unit u_exc_ctrl_unit (
      .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .ovf_i(ovf_i), .undef_i(undef_i),
      .irq_i(irq_i), .eret_i(eret_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
      .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .rd_denied_o(rd_denied_o),
      .redirect_o(redirect_o), .next_pc_o(next_pc_o), .kernel_o(kernel_o)
   );

   // {undef, ovf, irq[7:0], pc[31:0], code[3:0]}
   localparam int NV = 6;
   localparam logic [45:0] VEC [NV] = '{
      {1'b1, 1'b0, 8'h00, 32'h0040_0010, 4'd10},
      {1'b0, 1'b1, 8'h00, 32'h0040_0050, 4'd12},
      {1'b1, 1'b1, 8'h00, 32'h0040_0104, 4'd10},
      {1'b0, 1'b1, 8'h01, 32'h0040_0208, 4'd12},
      {1'b0, 1'b0, 8'h80, 32'h0041_0000, 4'd0},
      {1'b1, 1'b1, 8'h3C, 32'h0000_0004, 4'd10}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [4:0] sel, output logic [31:0] val);
      rd_sel_i = sel;
      #1;
      val = rd_data_o;
   endtask

   task automatic clear_in();
      ovf_i = 0; undef_i = 0; irq_i = '0; eret_i = 0; wr_en_i = 0;
   endtask

   initial begin
      #2_000_000;
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      #1;
      chk("R1 redirect", {31'd0, redirect_o}, 32'd0);
      chk("R1 kernel", {31'd0, kernel_o}, 32'd1);
      rd(5'd12, v); chk("R1 status", v, 32'd0);
      rd(5'd13, v); chk("R1 cause", v, 32'd0);
      rd(5'd14, v); chk("R1 epc", v, 32'd0);
      chk("R1 denied", {31'd0, rd_denied_o}, 32'd0);

      // R10 enable all lines, global enable on
      @(negedge clk);
      wr_en_i = 1; wr_data_i = 32'hFFFF_FF01;
      @(negedge clk);
      clear_in();
      rd(5'd12, v); chk("R10 status write", v, 32'h0000_FF01);

      // table walk: R2 R3 R4 R6 R7 R8
      for (int i = 0; i < NV; i++) begin
         logic [45:0] e;
         e = VEC[i];
         @(negedge clk);
         undef_i = e[45]; ovf_i = e[44]; irq_i = e[43:36]; pc_i = e[35:4];
         #1;
         chk($sformatf("R2 redirect v%0d", i), {31'd0, redirect_o}, 32'd1);
         chk($sformatf("R2 target v%0d", i), next_pc_o, HANDLER);
         @(negedge clk);
         clear_in();
         rd(5'd13, v);
         chk($sformatf("R3/R4 cause v%0d", i), v, {16'd0, e[43:36], 2'd0, e[3:0], 2'd0});
         rd(5'd14, v);
         chk($sformatf("R2 epc v%0d", i), v, e[35:4] - 32'd4);
         rd(5'd12, v);
         chk($sformatf("R7 exl v%0d", i), {30'd0, v[1], kernel_o}, 32'd3);
         @(negedge clk);
         eret_i = 1;
         #1;
         chk($sformatf("R8 return pc v%0d", i), next_pc_o, e[35:4] - 32'd4);
         @(negedge clk);
         eret_i = 0;
         #1;
         chk($sformatf("R8 user v%0d", i), {31'd0, kernel_o}, 32'd0);
      end

      // R9 user-mode read refused
      rd(5'd14, v);
      chk("R9 user read", v, 32'd0);
      chk("R9 denied", {31'd0, rd_denied_o}, 32'd1);

      // R10 user write ignored: try to turn enable off, irq still taken
      @(negedge clk);
      wr_en_i = 1; wr_data_i = 32'h0;
      @(negedge clk);
      clear_in();
      irq_i = 8'h01; pc_i = 32'h0000_1004;
      #1;
      chk("R10 user write ignored", {31'd0, redirect_o}, 32'd1);
      @(negedge clk);
      clear_in();
      rd(5'd12, v); chk("R10/R7 status after irq", v, 32'h0000_FF03);

      // R5 gating: mask only line 0, exl still set
      wr_en_i = 1; wr_data_i = 32'h0000_0103;
      @(negedge clk);
      clear_in();
      irq_i = 8'h01;
      #1;
      chk("R5 exl blocks", {31'd0, redirect_o}, 32'd0);
      @(negedge clk);
      clear_in();
      rd(5'd13, v); chk("R6 mirror untaken", v, 32'h0000_0100);
      rd(5'd99 % 32, v); chk("R9 other reg", v, 32'd0);
      eret_i = 1;
      @(negedge clk);
      clear_in();
      irq_i = 8'h02;
      #1;
      chk("R5 masked line", {31'd0, redirect_o}, 32'd0);
      @(negedge clk);
      irq_i = 8'h01; pc_i = 32'h0000_2000;
      #1;
      chk("R5 allowed line", {31'd0, redirect_o}, 32'd1);
      @(negedge clk);
      clear_in();
      // now kernel, exl=1; disable global enable with exl cleared
      wr_en_i = 1; wr_data_i = 32'h0000_0100;
      @(negedge clk);
      clear_in();
      irq_i = 8'h01;
      #1;
      chk("R5 global enable off", {31'd0, redirect_o}, 32'd0);

      // R11 trap and return together
      @(negedge clk);
      clear_in();
      ovf_i = 1; eret_i = 1; pc_i = 32'h0000_3008;
      #1;
      chk("R11 target", next_pc_o, HANDLER);
      @(negedge clk);
      clear_in();
      #1;
      chk("R11 kernel kept", {31'd0, kernel_o}, 32'd1);
      rd(5'd14, v); chk("R11 epc", v, 32'h0000_3004);
      rd(5'd13, v); chk("R11 cause", v, 32'h0000_0030);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule